// File: doc/BRIEF.md
# Vectored Interrupt Controller with Word Register Bus

This block gathers up to 32 interrupt request lines into one processor interrupt. Each line is fixed at build time as edge-sensitive or level-sensitive. Requests are latched into a status register and masked by an enable register to form pending bits. The controller reports the lowest-numbered pending line as a vector and drives one combined interrupt output. Software works it through eight 32-bit word registers on a simple request/response bus. It can acknowledge requests, set or clear enable bits atomically, and, while hardware capture is off, write status directly to test its handler.

A control register holds two bits. One gates the processor output. The other switches status capture from software writes to the input pins. A level line keeps its status bit set for as long as its pin is high, so acknowledging it has no effect until the source is serviced. An edge line sets its bit only on a low-to-high transition of its pin, which is sampled on the clock.

Top module: `irqc_top`

## Requirements
- R1: After synchronous reset, status, enable and control read as zero, the vector reads 0xFFFFFFFF, `irq_out` is low and `rd_valid` is low.
- R2: The pending word (byte address 0x04) reads as status AND enable, and reflects every register write from the next cycle.
- R3: The vector word (byte address 0x18) reads as the index of the lowest-numbered set pending bit, or 0xFFFFFFFF when no bit is pending.
- R4: `irq_out` is high exactly when control bit 0 is set and at least one pending bit is set.
- R5: A write to the control word (byte address 0x1C) stores only bits 1:0. Bit 0 is the output enable and bit 1 is the hardware-capture enable; bits 31:2 read as zero.
- R6: A write to the acknowledge word (byte address 0x0C) clears each status bit whose written bit is 1.
- R7: The enable word (byte address 0x08) takes a plain write. A write to byte address 0x10 ORs the value into enable. A write to byte address 0x14 clears each enable bit whose written bit is 1.
- R8: A write to the status word (byte address 0x00) replaces status while control bit 1 is clear, and is ignored while it is set.
- R9: While control bit 1 is set, a level line (its `EDGE_MASK` bit 0) whose pin is high sets its status bit on every clock, so an acknowledge does not clear it while the pin stays high.
- R10: While control bit 1 is set, an edge line (its `EDGE_MASK` bit 1) sets its status bit only on a rising pin edge, compared against the pin value of the previous clock. A pin that stays high or falls sets nothing.
- R11: While control bit 1 is clear, pin activity does not change status.
- R12: A read returns its data with `rd_valid` high on the cycle after the request. Writes to the pending and vector words are ignored. The acknowledge, set-enable and clear-enable words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits 4:2 select the word |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| irq_in | input | NUM_IRQ | Interrupt request pins |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
A corrupted status or enable bit shows up in the pending and vector words on the next read. If control bit 0 is set, it also shows on `irq_out` one cycle after the event that caused it. A stale edge-detect register would either miss a rising edge or capture a level that was already high. A read of status two cycles after the pin change exposes either fault. A wrong priority order gives a wrong vector as soon as two pending bits are set at once. The bench sets several pending bits together and then removes them one at a time.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned MAX_IRQ = 32;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned SEL_W   = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 3'd0,
        SEL_PEND   = 3'd1,
        SEL_ENA    = 3'd2,
        SEL_ACK    = 3'd3,
        SEL_SETENA = 3'd4,
        SEL_CLRENA = 3'd5,
        SEL_VEC    = 3'd6,
        SEL_CTRL   = 3'd7
    } reg_sel_e;

    // control word: bit 1 = hardware capture, bit 0 = output enable
    typedef struct packed {
        logic hw_en;
        logic out_en;
    } ctrl_t;

    typedef struct packed {
        logic              wr;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } wr_cmd_t;

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.hw_en  = w[1];
        c.out_en = w[0];
        return c;
    endfunction

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_IRQ   = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] pins,
    input  logic               hw_en,
    output logic [NUM_IRQ-1:0] set_mask
);

    logic [NUM_IRQ-1:0] pin_q;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= '0;
        else     pin_q <= pins;
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        if (EDGE_MASK[i]) begin : g_edge
            assign set_mask[i] = hw_en & pins[i] & ~pin_q[i];
        end else begin : g_level
            assign set_mask[i] = hw_en & pins[i];
        end
    end

endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  wr_cmd_t            cmd,
    input  logic [NUM_IRQ-1:0] set_mask,
    output logic [NUM_IRQ-1:0] status_q,
    output logic [NUM_IRQ-1:0] enable_q,
    output ctrl_t              ctrl_q
);

    logic [NUM_IRQ-1:0] status_n;
    logic [NUM_IRQ-1:0] enable_n;
    ctrl_t              ctrl_n;
    logic [NUM_IRQ-1:0] wbits;

    assign wbits = cmd.data[NUM_IRQ-1:0];

    always_comb begin
        status_n = status_q;
        enable_n = enable_q;
        ctrl_n   = ctrl_q;
        if (cmd.wr) begin
            unique case (cmd.sel)
                SEL_STATUS: if (!ctrl_q.hw_en) status_n = wbits;
                SEL_ENA:    enable_n = wbits;
                SEL_ACK:    status_n = status_q & ~wbits;
                SEL_SETENA: enable_n = enable_q | wbits;
                SEL_CLRENA: enable_n = enable_q & ~wbits;
                SEL_CTRL:   ctrl_n   = ctrl_from_word(cmd.data);
                default:    ;
            endcase
        end
        // pin capture is applied after the software update
        status_n = status_n | set_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
            ctrl_q   <= '0;
        end else begin
            status_q <= status_n;
            enable_q <= enable_n;
            ctrl_q   <= ctrl_n;
        end
    end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0] pending,
    output logic [DATA_W-1:0]  vector
);

    always_comb begin
        vector = '1;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (pending[i]) vector = DATA_W'(i);
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_IRQ   = 32,
    parameter int unsigned ADDR_W    = 5,
    parameter logic [31:0] EDGE_MASK = 32'h0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    output logic               rd_valid,
    output logic [31:0]        rd_data,
    input  logic [NUM_IRQ-1:0] irq_in,
    output logic               irq_out
);

    localparam int unsigned WORD_LSB = 2;
    localparam int unsigned MAP_BITS = WORD_LSB + SEL_W;

    reg_sel_e           sel;
    logic               in_map;
    wr_cmd_t            cmd;
    logic [NUM_IRQ-1:0] set_mask;
    logic [NUM_IRQ-1:0] status_q;
    logic [NUM_IRQ-1:0] enable_q;
    ctrl_t              ctrl_q;
    logic [NUM_IRQ-1:0] pending;
    logic [DATA_W-1:0]  vector;
    logic [DATA_W-1:0]  rd_next;

    assign sel    = reg_sel_e'(req_addr[MAP_BITS-1:WORD_LSB]);
    assign in_map = ((req_addr >> MAP_BITS) == '0);

    assign cmd.wr   = req_valid & req_write & in_map;
    assign cmd.sel  = sel;
    assign cmd.data = req_wdata;

    irqc_capture #(.NUM_IRQ(NUM_IRQ), .EDGE_MASK(EDGE_MASK)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .pins     (irq_in),
        .hw_en    (ctrl_q.hw_en),
        .set_mask (set_mask)
    );

    irqc_regfile #(.NUM_IRQ(NUM_IRQ)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .set_mask (set_mask),
        .status_q (status_q),
        .enable_q (enable_q),
        .ctrl_q   (ctrl_q)
    );

    assign pending = status_q & enable_q;

    irqc_prio #(.NUM_IRQ(NUM_IRQ)) u_prio (
        .pending (pending),
        .vector  (vector)
    );

    assign irq_out = ctrl_q.out_en & (|pending);

    always_comb begin
        rd_next = '0;
        if (in_map) begin
            unique case (sel)
                SEL_STATUS: rd_next[NUM_IRQ-1:0] = status_q;
                SEL_PEND:   rd_next[NUM_IRQ-1:0] = pending;
                SEL_ENA:    rd_next[NUM_IRQ-1:0] = enable_q;
                SEL_VEC:    rd_next = vector;
                SEL_CTRL:   rd_next[1:0] = ctrl_q;
                default:    rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= req_valid & ~req_write;
            if (req_valid && !req_write) rd_data <= rd_next;
        end
    end

endmodule

// File: rtl/irqc_checks.sv
module irqc_checks
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 32,
    parameter int unsigned ADDR_W  = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_write,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [31:0]        req_wdata,
    input logic               rd_valid,
    input logic               irq_out,
    input logic [NUM_IRQ-1:0] status_q,
    input logic [NUM_IRQ-1:0] enable_q,
    input logic [1:0]         ctrl_q,
    input logic [DATA_W-1:0]  vector
);

    localparam int unsigned IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    logic [NUM_IRQ-1:0] pend_c;
    logic [NUM_IRQ-1:0] below;
    logic [IDX_W-1:0]   vidx;
    logic               wr_ctrl;
    logic               wr_ack;

    assign pend_c  = status_q & enable_q;
    assign vidx    = vector[IDX_W-1:0];
    assign below   = (NUM_IRQ'(1) << vidx) - NUM_IRQ'(1);
    assign wr_ctrl = req_valid & req_write & (req_addr[4:2] == 3'd7);
    assign wr_ack  = req_valid & req_write & (req_addr[4:2] == 3'd3);

    assert_vec_empty_R3: assert property (@(posedge clk) disable iff (rst)
        (pend_c == '0) |-> (vector == '1));

    assert_vec_lowest_R3: assert property (@(posedge clk) disable iff (rst)
        (pend_c != '0) |-> (pend_c[vidx] && ((pend_c & below) == '0)));

    assert_irq_gate_R4: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (ctrl_q[0] && (pend_c != '0)));

    assert_ctrl_store_R5: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (ctrl_q == $past(req_wdata[1:0])));

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && !ctrl_q[1]) |=> ((status_q & $past(req_wdata[NUM_IRQ-1:0])) == '0));

    assert_rd_latency_R12: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(req_valid && !req_write));

endmodule

bind irqc_top irqc_checks #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_valid  (rd_valid),
    .irq_out   (irq_out),
    .status_q  (status_q),
    .enable_q  (enable_q),
    .ctrl_q    (ctrl_q),
    .vector    (vector)
);

// File: tb/irqc_top_bench.sv
`timescale 1ns/100ps
module irqc_top_bench;

    localparam int unsigned NIRQ  = 32;
    localparam logic [31:0] EMASK = 32'hFFFF_0000;
    localparam int          NVEC  = 25;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [NIRQ-1:0] irq_in = '0;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irqc_top #(.NUM_IRQ(NIRQ), .ADDR_W(5), .EDGE_MASK(EMASK)) u_irqc_top (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    // {is_read, byte address, write data, expected read, requirement number}
    localparam logic [73:0] VEC [NVEC] = '{
        {1'b0, 5'h00, 32'h0000_00F0, 32'h0,          4'd8},  // R8 direct status write
        {1'b1, 5'h00, 32'h0,         32'h0000_00F0, 4'd8},  // R8
        {1'b0, 5'h10, 32'h0000_0030, 32'h0,          4'd7},  // R7 set-enable
        {1'b1, 5'h08, 32'h0,         32'h0000_0030, 4'd7},  // R7
        {1'b1, 5'h04, 32'h0,         32'h0000_0030, 4'd2},  // R2 pending
        {1'b1, 5'h18, 32'h0,         32'h0000_0004, 4'd3},  // R3 vector
        {1'b0, 5'h14, 32'h0000_0010, 32'h0,          4'd7},  // R7 clear-enable
        {1'b1, 5'h08, 32'h0,         32'h0000_0020, 4'd7},  // R7
        {1'b1, 5'h18, 32'h0,         32'h0000_0005, 4'd3},  // R3
        {1'b0, 5'h0C, 32'h0000_0020, 32'h0,          4'd6},  // R6 acknowledge
        {1'b1, 5'h00, 32'h0,         32'h0000_00D0, 4'd6},  // R6
        {1'b1, 5'h04, 32'h0,         32'h0,          4'd2},  // R2
        {1'b1, 5'h18, 32'h0,         32'hFFFF_FFFF, 4'd3},  // R3 empty
        {1'b0, 5'h08, 32'hFFFF_FFFF, 32'h0,          4'd7},  // R7 plain write
        {1'b1, 5'h04, 32'h0,         32'h0000_00D0, 4'd2},  // R2
        {1'b1, 5'h18, 32'h0,         32'h0000_0004, 4'd3},  // R3
        {1'b0, 5'h1C, 32'hFFFF_FFFD, 32'h0,          4'd5},  // R5 control
        {1'b1, 5'h1C, 32'h0,         32'h0000_0001, 4'd5},  // R5
        {1'b0, 5'h04, 32'h0,         32'h0,          4'd12}, // R12 pending is read-only
        {1'b1, 5'h04, 32'h0,         32'h0000_00D0, 4'd12}, // R12
        {1'b0, 5'h18, 32'h0,         32'h0,          4'd12}, // R12 vector is read-only
        {1'b1, 5'h18, 32'h0,         32'h0000_0004, 4'd12}, // R12
        {1'b1, 5'h0C, 32'h0,         32'h0,          4'd12}, // R12 ack reads zero
        {1'b0, 5'h0C, 32'hFFFF_FFFF, 32'h0,          4'd6},  // R6
        {1'b1, 5'h18, 32'h0,         32'hFFFF_FFFF, 4'd3}   // R3
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        d = rd_valid ? rd_data : 32'hDEAD_BEEF;
        req_valid = 1'b0;
    endtask

    task automatic read_check(input int req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(1, {31'b0, irq_out}, 32'h0);
        check(1, {31'b0, rd_valid}, 32'h0);
        read_check(1, 5'h00, 32'h0);
        read_check(1, 5'h08, 32'h0);
        read_check(1, 5'h1C, 32'h0);
        read_check(1, 5'h18, 32'hFFFF_FFFF);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][73]) read_check(int'(VEC[i][3:0]), VEC[i][72:68], VEC[i][35:4]);
            else            bus_write(VEC[i][72:68], VEC[i][67:36]);
        end

        // R4 output gating (control = 1, all enabled, status empty)
        check(4, {31'b0, irq_out}, 32'h0);
        bus_write(5'h00, 32'h8000_0000);
        check(4, {31'b0, irq_out}, 32'h1);
        read_check(3, 5'h18, 32'd31);
        bus_write(5'h1C, 32'h0);
        check(4, {31'b0, irq_out}, 32'h0);
        bus_write(5'h1C, 32'h1);
        check(4, {31'b0, irq_out}, 32'h1);
        bus_write(5'h14, 32'h8000_0000);
        check(4, {31'b0, irq_out}, 32'h0);
        bus_write(5'h0C, 32'hFFFF_FFFF);

        // R11 no capture while hardware capture is off
        @(negedge clk);
        irq_in[2] = 1'b1; irq_in[20] = 1'b1;
        repeat (2) @(negedge clk);
        read_check(11, 5'h00, 32'h0);

        // R9 level line captured; R10 edge line already high gives nothing
        bus_write(5'h1C, 32'h3);
        read_check(9, 5'h00, 32'h0000_0004);
        check(4, {31'b0, irq_out}, 32'h1);
        @(negedge clk); irq_in[20] = 1'b0;
        @(negedge clk); irq_in[20] = 1'b1;
        @(negedge clk);
        read_check(10, 5'h00, 32'h0010_0004);
        bus_write(5'h0C, 32'h0010_0004);
        repeat (2) @(negedge clk);
        read_check(10, 5'h00, 32'h0000_0004);
        @(negedge clk); irq_in[20] = 1'b0;
        repeat (2) @(negedge clk);
        read_check(10, 5'h00, 32'h0000_0004);
        @(negedge clk); irq_in[2] = 1'b0;
        bus_write(5'h0C, 32'h0000_0004);
        read_check(9, 5'h00, 32'h0);
        check(4, {31'b0, irq_out}, 32'h0);

        // R8 status write ignored under hardware capture
        bus_write(5'h00, 32'h0000_00FF);
        read_check(8, 5'h00, 32'h0);

        // R12 read latency
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 5'h1C;
        @(negedge clk);
        check(12, {31'b0, rd_valid}, 32'h1);
        check(12, rd_data, 32'h3);
        req_valid = 1'b0;
        @(negedge clk);
        check(12, {31'b0, rd_valid}, 32'h0);

        done = 1'b1;
        finish_run();
    end

endmodule